// File: doc/BRIEF.md
# Dual-Port Address-Contention Arbiter

This block sits beside a two-port shared memory. It watches both ports' active-low selects and addresses and produces one active-low busy indication per port. When both ports are selected on the same address, the port whose request was present first goes ahead. The port that arrived later sees busy, and its write is gated off for as long as the collision lasts. If both requests appear in the same clock, the left port wins. After a winner is chosen, it keeps winning until the collision ends.

To build a wide memory from several copies, one copy runs as the arbitrating master. The other copies run in slave mode. A slave makes no decisions of its own: its external busy inputs only block writes, and each write waits a programmable number of cycles so that the master's result has settled first. The master also gives a combined flag that is high when either port is busy, for use as an interrupt. The memory array itself is outside this block. Its outputs are the busy pins and the per-port write-enable gates.

Top module: `dp_contention_arb`

## Requirements
- R1: In master mode, when the two addresses differ, both busy outputs are high in the same cycle.
- R2: When either select is high, both busy outputs are high, even if the addresses are equal. A port whose select is high never has its write-ok set.
- R3: A collision exists when both selects are low and the addresses are equal. If one port held the same select and address in the previous cycle and the other did not, the newcomer's busy goes low in that cycle and the earlier port's busy stays high.
- R4: If both ports start a colliding request in the same cycle, the right busy goes low and the left port proceeds.
- R5: The two busy outputs are never low at the same time.
- R6: While a collision continues with unchanged addresses, the chosen winner is kept, even after both requests have become equally old.
- R7: Busy is released in the same cycle that the addresses diverge or a select goes high. The port that was blocked then gets its write-ok in that cycle.
- R8: In master mode, write-ok for a port equals its write request AND its select being low AND its busy being high. The losing port's write is blocked.
- R9: In slave mode, both busy outputs stay high and any_busy stays low, even on a collision. A low external busy input blocks that port's write. In master mode the external busy inputs have no effect.
- R10: In slave mode, a port's write-ok is held low until its select and address have been unchanged for SETTLE_CYC cycles before the current one (default 2, so writes pass from the third cycle on). Changing the address restarts the wait.
- R11: any_busy is high exactly when one of the busy outputs is low.
- R12: After reset, with both selects high, the busy outputs are high and any_busy and both write-oks are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | 1 = slave (external busy inhibits only), 0 = master (arbitrates) |
| l_cs_n | input | 1 | Left port select, active low |
| l_addr | input | ADDR_W | Left port address |
| l_we | input | 1 | Left port write request |
| r_cs_n | input | 1 | Right port select, active low |
| r_addr | input | ADDR_W | Right port address |
| r_we | input | 1 | Right port write request |
| ext_busy_l_n | input | 1 | Left busy from the master, active low, used in slave mode |
| ext_busy_r_n | input | 1 | Right busy from the master, active low, used in slave mode |
| busy_l_n | output | 1 | Left busy, active low |
| busy_r_n | output | 1 | Right busy, active low |
| any_busy | output | 1 | High while either port is busy |
| l_wr_ok | output | 1 | Gated write enable for the left memory port |
| r_wr_ok | output | 1 | Gated write enable for the right memory port |

## Verification
The bench sets up a collision where the right port arrives first and then holds it for several cycles. A design that re-arbitrated each cycle would hand the win back to the left port once both requests are old. It also starts both ports in the same cycle, where a missing tie-break would raise busy on both sides or on neither. It checks that release and the blocked port's write happen in the very cycle the collision ends, not one cycle late. In slave mode it changes one address after the ports have settled, which catches a settle counter that does not restart, and it drives the external busy inputs low in master mode to catch a design that lets them leak into arbitration.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    localparam int NPORT = 2;
    localparam int PL    = 0;
    localparam int PR    = 1;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_LEFT  = 2'd1,
        WIN_RIGHT = 2'd2
    } winner_e;

    typedef struct packed {
        logic old;
        logic settled;
    } trk_t;

    // Earlier request wins; equal age falls to the left port.
    function automatic winner_e pick_fresh(input logic l_old, input logic r_old);
        return (r_old && !l_old) ? WIN_RIGHT : WIN_LEFT;
    endfunction

endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
    parameter int ADDR_W     = 11,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    output dpa_pkg::trk_t     trk_o
);
    localparam int CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] SETTLE_V = CW'(SETTLE_CYC);

    logic              last_en_q;
    logic [ADDR_W-1:0] last_addr_q;
    logic [CW-1:0]     age_q;
    logic              old;
    logic [CW-1:0]     age_now;

    always_comb begin
        old     = last_en_q && !cs_n && (addr == last_addr_q);
        age_now = old ? age_q : '0;
        trk_o.old     = old;
        trk_o.settled = !cs_n && (age_now >= SETTLE_V);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_en_q   <= 1'b0;
            last_addr_q <= '0;
            age_q       <= '0;
        end else begin
            last_en_q   <= !cs_n;
            last_addr_q <= addr;
            if (cs_n)
                age_q <= '0;
            else if (age_now < SETTLE_V)
                age_q <= age_now + CW'(1);
            else
                age_q <= age_now;
        end
    end

    // R10: a settled request has kept its address and select.
    p_settled_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (trk_o.settled && SETTLE_CYC > 0) |-> (!cs_n && $stable(addr)));

    // R10: a freshly raised select is never settled at once.
    p_fresh_unsettled_r10: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) && SETTLE_CYC > 0) |-> !trk_o.settled);

endmodule

// File: rtl/dpa_decide.sv
module dpa_decide (
    input  logic             clk,
    input  logic             rst,
    input  logic             match_i,
    input  logic             l_old_i,
    input  logic             r_old_i,
    output dpa_pkg::winner_e winner_o
);
    import dpa_pkg::*;

    winner_e win_q;
    logic    hold;

    always_comb begin
        hold = (win_q != WIN_NONE) && l_old_i;
        if (!match_i)
            winner_o = WIN_NONE;
        else if (hold)
            winner_o = win_q;
        else
            winner_o = pick_fresh(l_old_i, r_old_i);
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= WIN_NONE;
        else     win_q <= winner_o;
    end

    // R6: an ongoing collision keeps its winner.
    p_hold_winner_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && match_i && $past(match_i) && l_old_i)
            |-> (winner_o == $past(winner_o)));

    // R4: simultaneous newcomers resolve to the left port.
    p_tie_left_r4: assert property (@(posedge clk) disable iff (rst)
        (match_i && !l_old_i && !r_old_i) |-> (winner_o == WIN_LEFT));

    // R3: an older right request beats a new left one.
    p_older_right_r3: assert property (@(posedge clk) disable iff (rst)
        (match_i && r_old_i && !l_old_i && win_q == WIN_NONE) |-> (winner_o == WIN_RIGHT));

endmodule

// File: rtl/dpa_wgate.sv
module dpa_wgate (
    input  logic slave_i,
    input  logic we_i,
    input  logic cs_n_i,
    input  logic lose_i,
    input  logic ext_busy_n_i,
    input  logic settled_i,
    output logic wr_ok_o
);
    logic inhibit;

    always_comb begin
        if (slave_i) inhibit = !ext_busy_n_i || !settled_i;
        else         inhibit = lose_i;
        wr_ok_o = we_i && !cs_n_i && !inhibit;
    end

endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb #(
    parameter int ADDR_W     = 11,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slave_mode,
    input  logic              l_cs_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_we,
    input  logic              r_cs_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_we,
    input  logic              ext_busy_l_n,
    input  logic              ext_busy_r_n,
    output logic              busy_l_n,
    output logic              busy_r_n,
    output logic              any_busy,
    output logic              l_wr_ok,
    output logic              r_wr_ok
);
    import dpa_pkg::*;

    logic [ADDR_W-1:0] addr_a  [NPORT];
    logic              cs_n_a  [NPORT];
    logic              we_a    [NPORT];
    logic              ext_n_a [NPORT];
    logic              lose_a  [NPORT];
    logic              wok_a   [NPORT];
    trk_t              trk_a   [NPORT];
    logic              match;
    winner_e           winner;

    always_comb begin
        addr_a[PL]  = l_addr;       addr_a[PR]  = r_addr;
        cs_n_a[PL]  = l_cs_n;       cs_n_a[PR]  = r_cs_n;
        we_a[PL]    = l_we;         we_a[PR]    = r_we;
        ext_n_a[PL] = ext_busy_l_n; ext_n_a[PR] = ext_busy_r_n;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpa_port_track #(
            .ADDR_W     (ADDR_W),
            .SETTLE_CYC (SETTLE_CYC)
        ) u_trk (
            .clk   (clk),
            .rst   (rst),
            .cs_n  (cs_n_a[p]),
            .addr  (addr_a[p]),
            .trk_o (trk_a[p])
        );

        dpa_wgate u_gate (
            .slave_i      (slave_mode),
            .we_i         (we_a[p]),
            .cs_n_i       (cs_n_a[p]),
            .lose_i       (lose_a[p]),
            .ext_busy_n_i (ext_n_a[p]),
            .settled_i    (trk_a[p].settled),
            .wr_ok_o      (wok_a[p])
        );
    end

    assign match = !slave_mode && !l_cs_n && !r_cs_n && (l_addr == r_addr);

    dpa_decide u_dec (
        .clk      (clk),
        .rst      (rst),
        .match_i  (match),
        .l_old_i  (trk_a[PL].old),
        .r_old_i  (trk_a[PR].old),
        .winner_o (winner)
    );

    always_comb begin
        lose_a[PL] = (winner == WIN_RIGHT);
        lose_a[PR] = (winner == WIN_LEFT);
        busy_l_n   = !lose_a[PL];
        busy_r_n   = !lose_a[PR];
        any_busy   = (winner != WIN_NONE);
        l_wr_ok    = wok_a[PL];
        r_wr_ok    = wok_a[PR];
    end

    // R1: differing addresses never raise busy.
    p_no_busy_diff_r1: assert property (@(posedge clk) disable iff (rst)
        (l_addr != r_addr) |-> (busy_l_n && busy_r_n));

    // R2: a deselected port removes all busy.
    p_cs_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (l_cs_n || r_cs_n) |-> (busy_l_n && busy_r_n));

    // R5: never both sides busy.
    p_never_both_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_l_n || busy_r_n));

    // R8: master loser cannot write.
    p_gate_left_r8: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && !busy_l_n) |-> !l_wr_ok);
    p_gate_right_r8: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && !busy_r_n) |-> !r_wr_ok);

    // R9: slave never drives busy and honours external inhibit.
    p_slave_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        slave_mode |-> (busy_l_n && busy_r_n && !any_busy));
    p_slave_ext_r9: assert property (@(posedge clk) disable iff (rst)
        (slave_mode && (!ext_busy_l_n || !ext_busy_r_n))
            |-> (!(l_wr_ok && !ext_busy_l_n) && !(r_wr_ok && !ext_busy_r_n)));

    // R11: combined flag tracks the busy pins.
    p_any_r11: assert property (@(posedge clk) disable iff (rst)
        any_busy == (!busy_l_n || !busy_r_n));

endmodule

// File: tb/dp_contention_arb_bench.sv
module dp_contention_arb_bench;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          slave_mode = 1'b0;
    logic          l_cs_n = 1'b1, r_cs_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_we = 1'b0, r_we = 1'b0;
    logic          ext_busy_l_n = 1'b1, ext_busy_r_n = 1'b1;
    logic          busy_l_n, busy_r_n, any_busy, l_wr_ok, r_wr_ok;

    int            checks = 0;
    int            fails  = 0;
    bit            done   = 1'b0;
    logic [4:0]    expq [$];
    string         tagq [$];
    logic [4:0]    got;
    logic [4:0]    want;
    string         tag;

    always #5 clk = ~clk;

    dp_contention_arb #(.ADDR_W(AW), .SETTLE_CYC(2)) u_dp_contention_arb (
        .clk(clk), .rst(rst), .slave_mode(slave_mode),
        .l_cs_n(l_cs_n), .l_addr(l_addr), .l_we(l_we),
        .r_cs_n(r_cs_n), .r_addr(r_addr), .r_we(r_we),
        .ext_busy_l_n(ext_busy_l_n), .ext_busy_r_n(ext_busy_r_n),
        .busy_l_n(busy_l_n), .busy_r_n(busy_r_n), .any_busy(any_busy),
        .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
    );

    // Expected bits: {busy_l_n, busy_r_n, any_busy, l_wr_ok, r_wr_ok}
    task automatic drive(input logic sm,
                         input logic lcs, input logic [AW-1:0] la, input logic lwe,
                         input logic rcs, input logic [AW-1:0] ra, input logic rwe,
                         input logic ebl, input logic ebr,
                         input logic [4:0] exp_v, input string t);
        @(posedge clk);
        #1;
        slave_mode = sm;
        l_cs_n = lcs; l_addr = la; l_we = lwe;
        r_cs_n = rcs; r_addr = ra; r_we = rwe;
        ext_busy_l_n = ebl; ext_busy_r_n = ebr;
        expq.push_back(exp_v);
        tagq.push_back(t);
    endtask

    always @(negedge clk) begin
        if (expq.size() > 0) begin
            want = expq.pop_front();
            tag  = tagq.pop_front();
            got  = {busy_l_n, busy_r_n, any_busy, l_wr_ok, r_wr_ok};
            checks++;
            if (got !== want) begin
                fails++;
                $display("FAIL %s: got %b expected %b", tag, got, want);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // reset state, idle
        drive(0, 1, 11'd0, 0, 1, 11'd0, 0, 1, 1, 5'b11000, "R12 idle after reset");
        drive(0, 0, 11'd5, 1, 0, 11'd6, 1, 1, 1, 5'b11011, "R1 different addresses");
        drive(0, 1, 11'd7, 1, 0, 11'd7, 1, 1, 1, 5'b11001, "R2 left deselected, same address");
        drive(0, 0, 11'd7, 1, 0, 11'd7, 1, 1, 1, 5'b01101, "R3 R5 right earlier wins");
        drive(0, 0, 11'd7, 1, 0, 11'd7, 1, 1, 1, 5'b01101, "R6 winner held cycle 2");
        drive(0, 0, 11'd7, 1, 0, 11'd7, 1, 1, 1, 5'b01101, "R6 winner held cycle 3");
        drive(0, 0, 11'd7, 1, 0, 11'd8, 1, 1, 1, 5'b11011, "R7 release on address change");
        drive(0, 1, 11'd7, 1, 1, 11'd8, 1, 1, 1, 5'b11000, "R2 both deselected");
        drive(0, 0, 11'd9, 1, 0, 11'd9, 1, 1, 1, 5'b10110, "R4 R11 tie to left");
        drive(0, 0, 11'd9, 1, 0, 11'd9, 1, 1, 1, 5'b10110, "R8 loser stays blocked");
        drive(0, 1, 11'd9, 1, 0, 11'd9, 1, 1, 1, 5'b11001, "R7 release on deselect");
        drive(0, 0, 11'd3, 1, 0, 11'd4, 1, 1, 1, 5'b11011, "R1 different addresses again");
        drive(0, 0, 11'd3, 1, 0, 11'd3, 1, 1, 1, 5'b10110, "R3 left earlier wins");
        drive(0, 0, 11'd1, 1, 0, 11'd2, 1, 0, 0, 5'b11011, "R9 external busy ignored in master");
        drive(0, 1, 11'd1, 0, 1, 11'd2, 0, 1, 1, 5'b11000, "R2 idle before slave");
        drive(1, 0, 11'd10, 1, 0, 11'd10, 1, 1, 1, 5'b11000, "R10 slave wait cycle 1");
        drive(1, 0, 11'd10, 1, 0, 11'd10, 1, 1, 1, 5'b11000, "R10 slave wait cycle 2");
        drive(1, 0, 11'd10, 1, 0, 11'd10, 1, 1, 1, 5'b11011, "R9 R10 slave writes, no arbitration");
        drive(1, 0, 11'd10, 1, 0, 11'd10, 1, 0, 1, 5'b11001, "R9 external left busy blocks");
        drive(1, 0, 11'd10, 1, 0, 11'd10, 1, 1, 1, 5'b11011, "R9 external busy released");
        drive(1, 0, 11'd10, 1, 0, 11'd11, 1, 1, 1, 5'b11010, "R10 right address change restarts");
        drive(1, 0, 11'd10, 1, 0, 11'd11, 1, 1, 1, 5'b11010, "R10 right still waiting");
        drive(1, 0, 11'd10, 1, 0, 11'd11, 1, 1, 1, 5'b11011, "R10 right settled");
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule